// File: doc/BRIEF.md
# SPI Command Segment Sequencer

This block sits between the register interface of an SPI host and its serial shift engine. Software selects a target chip select, turns the sequencer on and writes a command word that gives the segment length in bytes. After a fixed start delay the sequencer runs full-duplex byte exchanges. For each byte it pops one byte from the transmit FIFO, hands it to the shift engine in a one-cycle request and waits for the acknowledge. It then pushes the byte that came back into the receive FIFO.

A segment ends early when the transmit FIFO has run dry or the receive FIFO is full. A sticky stall flag records which of the two stopped it. When a segment ends for any reason, the bytes left in the transmit FIFO are flushed. A command is rejected with an error pulse while a segment is still running. A chip select id that is out of range is refused, also with an error pulse. A software reset bit in the control word aborts all work and empties both FIFOs.

Top module: `spi_seg_seq`

## Requirements
- R1: Register writes are decoded from `wr_sel_i`: 0 selects control, 1 selects chip select id, 2 selects command, and 3 is ignored. Every command write stores bits 13:0 of the data, which `cmd_o` shows from the next cycle. Bits 7:0 of the command are the length in bytes. Bits 13:8 are stored but have no effect.
- R2: A command written while the enable bit is clear is stored but starts nothing. `ready_o` stays high and no exchange is requested.
- R3: A command written while `ready_o` is low is rejected. `err_busy_o` pulses in the cycle of the write, and the running segment continues unchanged.
- R4: After reset, `ready_o` is 1 and `active_o` is 0. Accepting a command drops `ready_o` and raises `active_o` at the same clock edge. `active_o` stays high until `ready_o` returns, so the two are never high together. The first request is issued START_DLY cycles after the accepting edge.
- R5: For each byte, `tx_pop_o` and `xfer_req_o` are high together for exactly one cycle, and `xfer_tx_o` carries the head byte of the transmit FIFO. When `xfer_ack_i` arrives, `rx_push_o` goes high in the same cycle and `rx_data_o` carries `xfer_rx_i`. A segment exchanges at most its length in bytes.
- R6: When a byte is due and `tx_empty_i` is high, `tx_stall_o` is set and the segment ends. The flag stays set until a software reset.
- R7: When a byte is due, the transmit FIFO is not empty and `rx_full_i` is high, `rx_stall_o` is set and the segment ends. The flag stays set until a software reset.
- R8: Every segment end gives a one-cycle `tx_flush_o` pulse, and `ready_o` returns at the next edge. A segment of length 0 exchanges no byte.
- R9: A chip select id write with a value of NUM_CS or more leaves `csid_o` unchanged and pulses `err_csid_o`. A write with a smaller value updates `csid_o`.
- R10: A control write with bit 30 set pulses `tx_flush_o` and `rx_flush_o` in that cycle. From the next edge the block is back in its reset state: enable cleared, chip select id 0, command 0, `ready_o` high, stall flags cleared and any segment aborted.
- R11: Control bit 31 is the enable bit. It is written by every control write that does not carry a software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | 32 | Register write data |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_data_i | input | 8 | Transmit FIFO head byte |
| tx_pop_o | output | 1 | Pop the transmit FIFO |
| tx_flush_o | output | 1 | Empty the transmit FIFO |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_push_o | output | 1 | Push into the receive FIFO |
| rx_data_o | output | 8 | Byte to push |
| rx_flush_o | output | 1 | Empty the receive FIFO |
| xfer_req_o | output | 1 | One-cycle byte exchange request |
| xfer_tx_o | output | 8 | Byte to shift out |
| xfer_ack_i | input | 1 | Exchange complete |
| xfer_rx_i | input | 8 | Byte shifted in |
| ready_o | output | 1 | Ready for a command |
| active_o | output | 1 | Segment in progress |
| tx_stall_o | output | 1 | Sticky transmit stall |
| rx_stall_o | output | 1 | Sticky receive stall |
| csid_o | output | CSID_W | Selected chip select |
| cmd_o | output | 14 | Last stored command word |
| err_busy_o | output | 1 | Command rejected while busy |
| err_csid_o | output | 1 | Chip select id out of range |

## Verification
The assertions assume that the shift engine raises `xfer_ack_i` only once per request. They also assume that `tx_data_i` holds the head byte whenever `tx_empty_i` is low, and that the FIFO flags change only in response to the block's own pops, pushes and flushes. The bench meets these by modelling both FIFOs as queues that are updated only from the block's outputs. Its shift engine returns each acknowledge a fixed number of cycles after the request and returns a fixed transform of the byte it was given. Register writes, including commands sent during a running segment, are driven only between clock edges.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_WAIT, PH_CHECK, PH_XFER, PH_DONE
  } phase_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CSID = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;

  localparam int CTRL_EN_BIT   = 31;
  localparam int CTRL_SRST_BIT = 30;
  localparam int CMD_W         = 14;
  localparam int LEN_W         = 8;
endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CSID_W = 2,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              ready_i,
  output logic [CSID_W-1:0] csid_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              srst_o,
  output logic              go_o,
  output logic              err_busy_o,
  output logic              err_csid_o
);
  logic en_q;
  logic wr_ctrl, wr_csid, wr_cmd, csid_ok;

  assign wr_ctrl = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign wr_csid = wr_en_i && (wr_sel_i == SEL_CSID);
  assign wr_cmd  = wr_en_i && (wr_sel_i == SEL_CMD);
  assign csid_ok = wr_data_i < DW'(NUM_CS);

  assign srst_o     = wr_ctrl && wr_data_i[CTRL_SRST_BIT];
  assign go_o       = wr_cmd && en_q && ready_i;
  assign err_busy_o = wr_cmd && en_q && !ready_i;
  assign err_csid_o = wr_csid && !csid_ok;
  assign len_o      = wr_data_i[LEN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      csid_o <= '0;
      cmd_o  <= '0;
    end else if (srst_o) begin
      en_q   <= 1'b0;
      csid_o <= '0;
      cmd_o  <= '0;
    end else begin
      if (wr_ctrl)            en_q   <= wr_data_i[CTRL_EN_BIT];
      if (wr_csid && csid_ok) csid_o <= wr_data_i[CSID_W-1:0];
      if (wr_cmd)             cmd_o  <= wr_data_i[CMD_W-1:0];
    end
  end
endmodule

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
  parameter int DLY = 3,
  localparam int CW = $clog2(DLY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (start_i)          cnt_q <= CW'(DLY);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             go_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             delay_done_i,
  input  logic             tx_empty_i,
  input  logic [7:0]       tx_data_i,
  input  logic             rx_full_i,
  input  logic             xfer_ack_i,
  input  logic [7:0]       xfer_rx_i,
  output logic             tx_pop_o,
  output logic             xfer_req_o,
  output logic [7:0]       xfer_tx_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             seg_end_o,
  output logic             ready_o,
  output logic             active_o,
  output logic             tx_stall_o,
  output logic             rx_stall_o
);
  phase_e ph_q, ph_d;
  logic [LEN_W-1:0] left_q;
  logic due, issue;

  assign due       = (ph_q == PH_CHECK) && (left_q != '0);
  assign issue     = due && !tx_empty_i && !rx_full_i;
  assign tx_pop_o  = issue;
  assign xfer_req_o = issue;
  assign xfer_tx_o = issue ? tx_data_i : 8'h00;
  assign rx_push_o = (ph_q == PH_XFER) && xfer_ack_i;
  assign rx_data_o = rx_push_o ? xfer_rx_i : 8'h00;
  assign seg_end_o = (ph_q == PH_DONE);

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (go_i) ph_d = PH_WAIT;
      PH_WAIT:  if (delay_done_i) ph_d = PH_CHECK;
      PH_CHECK: ph_d = issue ? PH_XFER : PH_DONE;
      PH_XFER:  if (xfer_ack_i) ph_d = PH_CHECK;
      PH_DONE:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      left_q     <= '0;
      ready_o    <= 1'b1;
      active_o   <= 1'b0;
      tx_stall_o <= 1'b0;
      rx_stall_o <= 1'b0;
    end else if (srst_i) begin
      ph_q       <= PH_IDLE;
      left_q     <= '0;
      ready_o    <= 1'b1;
      active_o   <= 1'b0;
      tx_stall_o <= 1'b0;
      rx_stall_o <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (go_i) begin
        left_q   <= len_i;
        ready_o  <= 1'b0;
        active_o <= 1'b1;
      end else if (rx_push_o) begin
        left_q <= left_q - LEN_W'(1);
      end
      // TX dry has priority over RX full
      if (due && tx_empty_i)                    tx_stall_o <= 1'b1;
      else if (due && rx_full_i)                rx_stall_o <= 1'b1;
      if (seg_end_o) begin
        ready_o  <= 1'b1;
        active_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_seg_seq.sv
module spi_seg_seq
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS    = 4,
  parameter int START_DLY = 3,
  localparam int CSID_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int DLY_EFF  = (START_DLY < 1) ? 1 : START_DLY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic              tx_empty_i,
  input  logic [7:0]        tx_data_i,
  output logic              tx_pop_o,
  output logic              tx_flush_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_flush_o,
  output logic              xfer_req_o,
  output logic [7:0]        xfer_tx_o,
  input  logic              xfer_ack_i,
  input  logic [7:0]        xfer_rx_i,
  output logic              ready_o,
  output logic              active_o,
  output logic              tx_stall_o,
  output logic              rx_stall_o,
  output logic [CSID_W-1:0] csid_o,
  output logic [13:0]       cmd_o,
  output logic              err_busy_o,
  output logic              err_csid_o
);
  logic srst, go, dly_done, seg_end;
  logic [LEN_W-1:0] len;

  spi_seq_regs #(.NUM_CS(NUM_CS), .CSID_W(CSID_W), .DW(32)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .ready_i(ready_o), .csid_o, .cmd_o, .len_o(len),
    .srst_o(srst), .go_o(go), .err_busy_o, .err_csid_o
  );

  spi_seq_timer #(.DLY(DLY_EFF)) u_timer (
    .clk_i, .rst_ni, .clr_i(srst), .start_i(go), .done_o(dly_done)
  );

  spi_seq_engine u_engine (
    .clk_i, .rst_ni, .srst_i(srst), .go_i(go), .len_i(len),
    .delay_done_i(dly_done), .tx_empty_i, .tx_data_i, .rx_full_i,
    .xfer_ack_i, .xfer_rx_i, .tx_pop_o, .xfer_req_o, .xfer_tx_o,
    .rx_push_o, .rx_data_o, .seg_end_o(seg_end), .ready_o, .active_o,
    .tx_stall_o, .rx_stall_o
  );

  assign tx_flush_o = seg_end || srst;
  assign rx_flush_o = srst;
endmodule

// File: rtl/spi_seg_seq_chk.sv
module spi_seg_seq_chk #(
  parameter int NUM_CS = 4,
  parameter int CSID_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic              srst_bit_i,
  input logic              tx_empty_i,
  input logic              rx_full_i,
  input logic              tx_flush_o,
  input logic              rx_push_o,
  input logic              xfer_req_o,
  input logic              ready_o,
  input logic              active_o,
  input logic              tx_stall_o,
  input logic              rx_stall_o,
  input logic [CSID_W-1:0] csid_o,
  input logic              err_busy_o,
  input logic              err_csid_o
);
  logic srst;
  assign srst = wr_en_i && (wr_sel_i == 2'd0) && srst_bit_i;

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_busy_o |-> !ready_o); // R3
  AST_READY_ACTIVE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !ready_o); // R4
  AST_REQ_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> (!tx_empty_i && !rx_full_i && active_o)); // R5
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |=> !xfer_req_o); // R5
  AST_PUSH_IN_SEGMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> active_o); // R5
  AST_TX_STALL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stall_o && !srst) |=> tx_stall_o); // R6
  AST_RX_STALL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_stall_o && !srst) |=> rx_stall_o); // R7
  AST_END_RETURNS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_o |=> (ready_o && !active_o)); // R8
  AST_CSID_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(csid_o) < NUM_CS); // R9
  AST_CSID_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_csid_o |=> $stable(csid_o)); // R9
  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (ready_o && !active_o && !tx_stall_o && !rx_stall_o && csid_o == '0)); // R10
endmodule

bind spi_seg_seq spi_seg_seq_chk #(.NUM_CS(NUM_CS), .CSID_W(CSID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .srst_bit_i(wr_data_i[30]), .tx_empty_i(tx_empty_i), .rx_full_i(rx_full_i),
  .tx_flush_o(tx_flush_o), .rx_push_o(rx_push_o), .xfer_req_o(xfer_req_o),
  .ready_o(ready_o), .active_o(active_o), .tx_stall_o(tx_stall_o),
  .rx_stall_o(rx_stall_o), .csid_o(csid_o), .err_busy_o(err_busy_o),
  .err_csid_o(err_csid_o)
);

// File: tb/tb_spi_seg_seq.sv
module tb_spi_seg_seq;
  localparam int NUM_CS = 4;
  localparam int DLY    = 3;
  localparam int RX_DEP = 4;
  localparam int LAT    = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic tx_empty = 1'b1, rx_full = 1'b0, ack = 1'b0;
  logic [7:0] tx_data = '0, rx_byte = '0;
  logic tx_pop, tx_flush, rx_push, rx_flush, req, ready, active, tst, rst_l, ebusy, ecsid;
  logic [7:0] rx_data, xtx;
  logic [1:0] csid;
  logic [13:0] cmd;

  always #5 clk = ~clk;

  spi_seg_seq #(.NUM_CS(NUM_CS), .START_DLY(DLY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .tx_empty_i(tx_empty), .tx_data_i(tx_data), .tx_pop_o(tx_pop), .tx_flush_o(tx_flush),
    .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_data), .rx_flush_o(rx_flush),
    .xfer_req_o(req), .xfer_tx_o(xtx), .xfer_ack_i(ack), .xfer_rx_i(rx_byte),
    .ready_o(ready), .active_o(active), .tx_stall_o(tst), .rx_stall_o(rst_l),
    .csid_o(csid), .cmd_o(cmd), .err_busy_o(ebusy), .err_csid_o(ecsid)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  int eng_busy = 0, eng_cnt = 0;
  logic [7:0] eng_byte = '0;
  // reference model state
  int m_en = 0, m_csid = 0, m_cmd = 0, m_ready = 1, m_active = 0, m_txs = 0, m_rxs = 0;
  int m_ph = 0, m_cnt = 0, m_left = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit srst, wc, ws, wm, issue, push;
    tx_empty = (txq.size() == 0);
    tx_data  = tx_empty ? 8'h00 : txq[0];
    rx_full  = (rxq.size() >= RX_DEP);
    ack      = (eng_busy != 0) && (eng_cnt == 0);
    rx_byte  = eng_byte ^ 8'h5A;
    #1;
    wc = wr_en && wr_sel == 2'd0;
    ws = wr_en && wr_sel == 2'd1;
    wm = wr_en && wr_sel == 2'd2;
    srst  = wc && wr_data[30];
    issue = (m_ph == 2) && (m_left > 0) && !tx_empty && !rx_full;
    push  = (m_ph == 3) && ack;
    chk("R4", "ready", int'(ready), m_ready);
    chk("R4", "active", int'(active), m_active);
    chk("R6", "tx_stall", int'(tst), m_txs);
    chk("R7", "rx_stall", int'(rst_l), m_rxs);
    chk("R9", "csid", int'(csid), m_csid);
    chk("R1", "cmd", int'(cmd), m_cmd);
    chk("R3", "err_busy", int'(ebusy), int'(wm && m_en != 0 && m_ready == 0));
    chk("R9", "err_csid", int'(ecsid), int'(ws && wr_data >= NUM_CS));
    chk("R5", "tx_pop", int'(tx_pop), int'(issue));
    chk("R5", "xfer_req", int'(req), int'(issue));
    if (issue) chk("R5", "xfer_tx", int'(xtx), int'(tx_data));
    chk("R5", "rx_push", int'(rx_push), int'(push));
    if (push) chk("R5", "rx_data", int'(rx_data), int'(rx_byte));
    chk("R8", "tx_flush", int'(tx_flush), int'(m_ph == 4 || srst));
    chk("R10", "rx_flush", int'(rx_flush), int'(srst));
    // environment
    if (tx_pop && txq.size() > 0) void'(txq.pop_front());
    if (tx_flush) txq.delete();
    if (rx_push) rxq.push_back(rx_data);
    if (rx_flush) rxq.delete();
    if (ack) eng_busy = 0;
    else if (eng_busy != 0) eng_cnt--;
    if (req) begin eng_busy = 1; eng_cnt = LAT; eng_byte = xtx; end
    // model
    if (srst) begin
      m_en = 0; m_csid = 0; m_cmd = 0; m_ready = 1; m_active = 0;
      m_txs = 0; m_rxs = 0; m_ph = 0; m_cnt = 0; m_left = 0;
    end else begin
      if (wm && m_en != 0 && m_ready != 0) begin
        m_ph = 1; m_cnt = DLY; m_left = int'(wr_data[7:0]); m_ready = 0; m_active = 1;
      end else begin
        case (m_ph)
          1: begin if (m_cnt == 1) m_ph = 2; m_cnt--; end
          2: begin
            if (m_left == 0) m_ph = 4;
            else if (tx_empty) begin m_txs = 1; m_ph = 4; end
            else if (rx_full) begin m_rxs = 1; m_ph = 4; end
            else m_ph = 3;
          end
          3: if (ack) begin m_left--; m_ph = 2; end
          4: begin m_ready = 1; m_active = 0; m_ph = 0; end
          default: ;
        endcase
      end
      if (wc) m_en = int'(wr_data[31]);  // R11
      if (ws && wr_data < NUM_CS) m_csid = int'(wr_data);
      if (wm) m_cmd = int'(wr_data[13:0]);
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200 && !(ready && m_ready != 0); i++) step();
  endtask

  task automatic fresh();
    wr(2'd0, 32'h4000_0000);
    wr(2'd0, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R4", "reset ready", int'(ready), 1);
    chk("R4", "reset active", int'(active), 0);
    chk("R10", "reset cmd", int'(cmd), 0);
    // R9 chip select id
    wr(2'd1, 32'd2); step();
    chk("R9", "csid accepted", int'(csid), 2);
    wr(2'd1, 32'd4); wr(2'd1, 32'd7);
    chk("R9", "csid kept", int'(csid), 2);
    wr(2'd1, 32'd3);
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R1", "select 3 ignored", int'(csid), 3);
    // R2 disabled command
    txq.push_back(8'h11);
    wr(2'd2, 32'h0000_3F02);
    run(10);
    chk("R2", "disabled ready", int'(ready), 1);
    chk("R1", "cmd stored", int'(cmd), 14'h3F02);
    txq.delete();
    // normal 3-byte segment with busy command
    wr(2'd0, 32'h8000_0000);
    txq.push_back(8'h10); txq.push_back(8'h21); txq.push_back(8'h32);
    wr(2'd2, 32'd3);
    run(4);
    wr(2'd2, 32'd1);   // R3 rejected
    wait_ready();
    chk("R5", "rx count", rxq.size(), 3);
    if (rxq.size() == 3) begin
      chk("R5", "rx byte0", int'(rxq[0]), int'(8'h10 ^ 8'h5A));
      chk("R5", "rx byte2", int'(rxq[2]), int'(8'h32 ^ 8'h5A));
    end
    // R6 transmit stall
    txq.push_back(8'hA0);
    wr(2'd2, 32'd3);
    wait_ready(); run(2);
    chk("R6", "tx stall set", int'(tst), 1);
    // R8 leftover flush
    fresh();
    for (int i = 0; i < 5; i++) txq.push_back(8'(i + 1));
    wr(2'd2, 32'd2);
    wait_ready(); run(2);
    chk("R8", "leftover flushed", txq.size(), 0);
    // R7 receive stall
    fresh();
    for (int i = 0; i < 6; i++) txq.push_back(8'(8'h40 + i));
    wr(2'd2, 32'd6);
    wait_ready(); run(2);
    chk("R7", "rx stall set", int'(rst_l), 1);
    chk("R7", "rx depth", rxq.size(), RX_DEP);
    // R8 zero length
    fresh();
    txq.push_back(8'h77);
    wr(2'd2, 32'd0);
    wait_ready(); run(2);
    chk("R8", "zero length no pop", rxq.size(), 0);
    // R10 soft reset mid segment
    wr(2'd0, 32'h8000_0000);
    for (int i = 0; i < 4; i++) txq.push_back(8'(8'hC0 + i));
    wr(2'd2, 32'd4);
    run(6);
    wr(2'd0, 32'hC000_0000);
    chk("R10", "abort ready", int'(ready), 1);
    chk("R10", "abort active", int'(active), 0);
    run(4);
    chk("R11", "enable cleared", int'(ready), 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule